// File: doc/BRIEF.md
# Multi-Channel SAR Converter Serial Reader

This block is a serial-bus master. It fetches one conversion result from a family of successive-approximation converters. The attached converter may have one, two, four or eight analog inputs, and 10, 12 or 13 bits of resolution. Two select inputs name the variant for each request. A request also carries a channel number and a differential flag.

On a start pulse the block checks the request. It lowers chip select and sends a one-byte command, except on one-input parts, which only receive. It then clocks in two reply bytes while chip select stays low. It rebuilds the sample from the bit positions that belong to the variant and presents it with a one-cycle done strobe. The 13-bit variant gives a two's-complement result, sign-extended to the output width. A request the variant cannot serve raises a one-cycle error strobe and leaves the bus untouched.

The bus uses mode 0: the clock idles low, data is sampled on the rising edge and changed on the falling edge, most significant bit first. The serial clock period is `2*CLK_DIV` system clocks.

Top module: `sar_spi_reader`

## Requirements
- R1: After reset, cs_n_o is high, sclk_o and mosi_o are low, and busy_o, done_o and err_o are low.
- R2: sclk_o is low whenever cs_n_o is high. Rising edges of sclk_o are exactly 2*CLK_DIV system clocks apart. mosi_o changes only while sclk_o is low.
- R3: inputs_sel_i=1 selects two inputs. The command byte is then start bit 1 at bit 4, the inverse of diff_i at bit 3, chan_i[0] at bit 2, and zeros elsewhere. It is sent MSB first in the first 8 serial clocks.
- R4: inputs_sel_i=2 selects four inputs and inputs_sel_i=3 selects eight. The command byte is then start bit 1 at bit 6, the inverse of diff_i at bit 5, chan_i at bits 4:2, and zeros elsewhere.
- R5: inputs_sel_i=0 selects one input. The frame is then exactly 16 serial clocks, and mosi_o stays low for the whole transaction.
- R6: Multi-input frames are exactly 24 serial clocks. chip select falls once and stays low from the command byte through both reply bytes.
- R7: res_sel_i=0 (10 bits) on multi-input parts gives sample = (byte0<<2)|(byte1>>6), zero-extended. byte0 is the first received reply byte and byte1 the second.
- R8: res_sel_i=1 (12 bits) on multi-input parts gives sample = (byte0<<4)|(byte1>>4), zero-extended.
- R9: On one-input parts, 10 bits gives the low 10 bits of (byte0<<5)|(byte1>>3), and 12 bits gives the low 12 bits of (byte0<<7)|(byte1>>1), both zero-extended.
- R10: res_sel_i=2 (13-bit signed, one-input only) gives {byte0[4:0],byte1}, sign-extended from bit 12 to OUT_W bits.
- R11: Some requests are invalid: res_sel_i=3, res_sel_i=2 with more than one input, or chan_i at or above the input count. Such a request pulses err_o for one cycle, one cycle after start, with no chip-select activity and busy_o staying low.
- R12: done_o pulses for one cycle with the sample valid while busy_o is high. start_i is ignored while busy_o is high. chip select stays high for at least 2*CLK_DIV system clocks between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, taken when idle |
| inputs_sel_i | input | 2 | Input count: 0=1, 1=2, 2=4, 3=8 |
| res_sel_i | input | 2 | Resolution: 0=10, 1=12, 2=13 signed, 3 invalid |
| chan_i | input | 3 | Channel or first input of a differential pair |
| diff_i | input | 1 | Differential request |
| busy_o | output | 1 | Transaction in progress, including the closing gap |
| done_o | output | 1 | One-cycle strobe, sample valid |
| err_o | output | 1 | One-cycle strobe for a rejected request |
| sample_o | output | OUT_W | Rebuilt sample |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
A wrong bit counter or frame length would show up in the same transaction. The serial-clock count differs from 16 or 24, and the sample is shifted by one or more bits when done rises. A wrong latched variant or command register would show in the first eight MOSI bits captured by the slave model, or in the wrong slice being rebuilt. A stuck state would show as a missing done strobe, or a chip select that never rises, within one frame time. The bench mixes seeded random variants and reply words with directed sign, range and busy-start corner cases.

// File: rtl/sar_pkg.sv
package sar_pkg;
   localparam int CH_W = 3;
   localparam int CMD_W = 8;
   localparam int RX_W = 16;
   localparam int FRAME_W = CMD_W + RX_W;
   localparam int RAW_W = 13;

   typedef enum logic [1:0] {IN1 = 2'd0, IN2 = 2'd1, IN4 = 2'd2, IN8 = 2'd3} inputs_e;
   typedef enum logic [1:0] {RES10 = 2'd0, RES12 = 2'd1, RES13S = 2'd2, RESBAD = 2'd3} res_e;
endpackage

// File: rtl/sar_cmd_enc.sv
module sar_cmd_enc
   import sar_pkg::*;
(
   input  inputs_e             inputs_i,
   input  res_e                res_i,
   input  logic [CH_W-1:0]     chan_i,
   input  logic                diff_i,
   output logic [CMD_W-1:0]    cmd_o,
   output logic                with_cmd_o,
   output logic                bad_o
);
   logic [CH_W:0] n_inputs;

   always_comb begin
      n_inputs = (CH_W+1)'(1) << inputs_i;
      bad_o = (res_i == RESBAD) || (res_i == RES13S && inputs_i != IN1)
            || ({1'b0, chan_i} >= n_inputs);
      with_cmd_o = (inputs_i != IN1);
      cmd_o = '0;
      case (inputs_i)
         IN2: begin
            cmd_o[4] = 1'b1;
            cmd_o[3] = ~diff_i;
            cmd_o[2] = chan_i[0];
         end
         IN4, IN8: begin
            cmd_o[6]   = 1'b1;
            cmd_o[5]   = ~diff_i;
            cmd_o[4:2] = chan_i;
         end
         default: cmd_o = '0;
      endcase
   end
endmodule

// File: rtl/sar_spi_engine.sv
module sar_spi_engine
   import sar_pkg::*;
#(
   parameter int CLK_DIV = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               launch_i,
   input  logic               with_cmd_i,
   input  logic [CMD_W-1:0]   cmd_i,
   input  logic               miso_i,
   output logic               busy_o,
   output logic               fin_o,
   output logic [RX_W-1:0]    rx_o,
   output logic               cs_n_o,
   output logic               sclk_o,
   output logic               mosi_o
);
   localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam int CNT_W = $clog2(FRAME_W + 1);

   typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} st_e;

   st_e                state;
   logic               tick;
   logic [CNT_W-1:0]   bit_cnt, nbits;
   logic [FRAME_W-1:0] tx_q;

   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
      if (CLK_DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         logic [DIV_W-1:0] div_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        div_cnt <= '0;
            else if (state == ST_IDLE || tick) div_cnt <= '0;
            else                               div_cnt <= div_cnt + 1'b1;
         end
         assign tick = (div_cnt == DIV_W'(CLK_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bit_cnt <= '0;
         nbits   <= '0;
         tx_q    <= '0;
         rx_o    <= '0;
         cs_n_o  <= 1'b1;
         sclk_o  <= 1'b0;
         fin_o   <= 1'b0;
      end else begin
         fin_o <= 1'b0;
         case (state)
            ST_IDLE: if (launch_i) begin
               state   <= ST_SHIFT;
               cs_n_o  <= 1'b0;
               bit_cnt <= '0;
               nbits   <= with_cmd_i ? CNT_W'(FRAME_W) : CNT_W'(RX_W);
               tx_q    <= with_cmd_i ? {cmd_i, {RX_W{1'b0}}} : '0;
            end
            ST_SHIFT: if (tick) begin
               if (!sclk_o) begin
                  sclk_o  <= 1'b1;
                  rx_o    <= {rx_o[RX_W-2:0], miso_i};
                  bit_cnt <= bit_cnt + 1'b1;
               end else begin
                  sclk_o <= 1'b0;
                  if (bit_cnt == nbits) begin
                     cs_n_o  <= 1'b1;
                     state   <= ST_GAP;
                     bit_cnt <= '0;
                     fin_o   <= 1'b1;
                  end else begin
                     tx_q <= tx_q << 1;
                  end
               end
            end
            ST_GAP: if (tick) begin
               if (bit_cnt == CNT_W'(1)) state <= ST_IDLE;
               else                      bit_cnt <= bit_cnt + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign mosi_o = tx_q[FRAME_W-1];
   assign busy_o = (state != ST_IDLE);

   assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> !sclk_o);
   assert_mosi_on_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mosi_o) |-> !sclk_o);
   assert_frame_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SHIFT) |-> (bit_cnt <= nbits));
   assert_gap_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |=> cs_n_o);
endmodule

// File: rtl/sar_result_align.sv
module sar_result_align
   import sar_pkg::*;
#(
   parameter int OUT_W = 16
) (
   input  inputs_e            inputs_i,
   input  res_e               res_i,
   input  logic [RX_W-1:0]    rx_i,
   output logic [OUT_W-1:0]   sample_o
);
   logic [7:0]       b0, b1;
   logic [RAW_W-1:0] raw;
   logic             signed_mode;

   assign b0 = rx_i[15:8];
   assign b1 = rx_i[7:0];
   assign signed_mode = (res_i == RES13S);

   always_comb begin
      raw = '0;
      if (signed_mode)                        raw = {b0[4:0], b1};
      else if (inputs_i == IN1 && res_i == RES10) raw = {3'b0, b0[4:0], b1[7:3]};
      else if (inputs_i == IN1)               raw = {1'b0, b0[4:0], b1[7:1]};
      else if (res_i == RES10)                raw = {3'b0, b0, b1[7:6]};
      else                                    raw = {1'b0, b0, b1[7:4]};
   end

   generate
      if (OUT_W < RAW_W) begin : g_bad_w
         $error("OUT_W must be at least 13");
      end else if (OUT_W == RAW_W) begin : g_exact
         assign sample_o = raw;
      end else begin : g_ext
         assign sample_o = {{(OUT_W-RAW_W){signed_mode & raw[RAW_W-1]}}, raw};
      end
   endgenerate
endmodule

// File: rtl/sar_spi_reader.sv
module sar_spi_reader
   import sar_pkg::*;
#(
   parameter int CLK_DIV = 2,
   parameter int OUT_W   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [1:0]       inputs_sel_i,
   input  logic [1:0]       res_sel_i,
   input  logic [2:0]       chan_i,
   input  logic             diff_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             err_o,
   output logic [OUT_W-1:0] sample_o,
   output logic             cs_n_o,
   output logic             sclk_o,
   output logic             mosi_o,
   input  logic             miso_i
);
   logic [CMD_W-1:0] cmd;
   logic             with_cmd, bad, launch;
   logic [RX_W-1:0]  rx;
   inputs_e          in_q;
   res_e             res_q;

   sar_cmd_enc u_enc (
      .inputs_i   (inputs_e'(inputs_sel_i)),
      .res_i      (res_e'(res_sel_i)),
      .chan_i     (chan_i),
      .diff_i     (diff_i),
      .cmd_o      (cmd),
      .with_cmd_o (with_cmd),
      .bad_o      (bad)
   );

   assign launch = start_i && !busy_o && !bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q  <= IN1;
         res_q <= RES10;
         err_o <= 1'b0;
      end else begin
         err_o <= start_i && !busy_o && bad;
         if (launch) begin
            in_q  <= inputs_e'(inputs_sel_i);
            res_q <= res_e'(res_sel_i);
         end
      end
   end

   sar_spi_engine #(.CLK_DIV(CLK_DIV)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch_i   (launch),
      .with_cmd_i (with_cmd),
      .cmd_i      (cmd),
      .miso_i     (miso_i),
      .busy_o     (busy_o),
      .fin_o      (done_o),
      .rx_o       (rx),
      .cs_n_o     (cs_n_o),
      .sclk_o     (sclk_o),
      .mosi_o     (mosi_o)
   );

   sar_result_align #(.OUT_W(OUT_W)) u_align (
      .inputs_i (in_q),
      .res_i    (res_q),
      .rx_i     (rx),
      .sample_o (sample_o)
   );

   assert_err_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (cs_n_o && !busy_o));
   assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));
   assert_done_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> busy_o);
   assert_rx_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && in_q == IN1) |-> !mosi_o);
endmodule

// File: tb/sar_spi_reader_tb.sv
module sar_spi_reader_tb;
   localparam int CLK_DIV = 2;
   localparam int OUT_W   = 16;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, diff = 1'b0;
   logic [1:0] in_sel = '0, res_sel = '0;
   logic [2:0] chan = '0;
   logic busy, done, err, cs_n, sclk, mosi, miso;
   logic [OUT_W-1:0] sample;

   int checks = 0, errors = 0;
   int cyc = 0, rises = 0, cs_falls = 0, last_rise = -1, last_cs_rise = -1;
   logic period_bad = 1'b0, gap_bad = 1'b0;
   logic [23:0] sl_out = '0, frame = '0, mosi_bits = '0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc = cyc + 1;

   sar_spi_reader #(.CLK_DIV(CLK_DIV), .OUT_W(OUT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .inputs_sel_i(in_sel),
      .res_sel_i(res_sel), .chan_i(chan), .diff_i(diff), .busy_o(busy),
      .done_o(done), .err_o(err), .sample_o(sample), .cs_n_o(cs_n),
      .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso));

   assign miso = sl_out[23];

   always @(negedge cs_n) begin
      sl_out = frame;
      cs_falls = cs_falls + 1;
      if (last_cs_rise >= 0 && (cyc - last_cs_rise) < 2*CLK_DIV) gap_bad = 1'b1;
   end
   always @(posedge cs_n) last_cs_rise = cyc;
   always @(posedge sclk) begin
      mosi_bits = {mosi_bits[22:0], mosi};
      if (rises > 0 && (cyc - last_rise) != 2*CLK_DIV) period_bad = 1'b1;
      last_rise = cyc;
      rises = rises + 1;
   end
   always @(negedge sclk) sl_out = sl_out << 1;

   initial begin
      #2_000_000;
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_sample(input int ins, input int res, input logic [15:0] reply);
      int b0, b1, v;
      b0 = int'(reply[15:8]);
      b1 = int'(reply[7:0]);
      if (res == 2) begin
         v = ((b0 % 32) * 256) + b1;
         if (v >= 4096) v = v - 8192;
      end else if (ins == 0) begin
         v = (res == 0) ? (((b0 << 5) | (b1 >> 3)) % 1024) : (((b0 << 7) | (b1 >> 1)) % 4096);
      end else begin
         v = (res == 0) ? ((b0 << 2) | (b1 >> 6)) : ((b0 << 4) | (b1 >> 4));
      end
      return v[15:0];
   endfunction

   function automatic logic [7:0] exp_cmd(input int ins, input int ch, input logic d);
      int v;
      if (ins == 1) v = 16 + (d ? 0 : 8) + ch * 4;
      else          v = 64 + (d ? 0 : 32) + ch * 4;
      return v[7:0];
   endfunction

   task automatic txn(input int ins, input int res, input int ch, input logic d,
                      input logic [15:0] reply, input logic poke_busy);
      int waited = 0;
      logic got = 1'b0;
      frame = (ins == 0) ? {reply, 8'h00} : {8'($urandom), reply};
      @(negedge clk);
      rises = 0; cs_falls = 0; mosi_bits = '0; period_bad = 1'b0; gap_bad = 1'b0;
      in_sel = 2'(ins); res_sel = 2'(res); chan = 3'(ch); diff = d; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!got && waited < 400) begin
         if (poke_busy && waited == 20) begin
            in_sel = 2'd3; chan = 3'd7; start = 1'b1;   // R12: start while busy
            @(negedge clk);
            start = 1'b0;
         end
         if (done) begin
            got = 1'b1;
            check((res == 2) ? "R10" : (ins == 0) ? "R9" : (res == 0) ? "R7" : "R8",
                  32'(sample), 32'(exp_sample(ins, res, reply)));
            check("R12 busy during done", 32'(busy), 32'd1);
         end else begin
            @(negedge clk);
            waited = waited + 1;
         end
      end
      check("R12 done seen", 32'(got), 32'd1);
      check(ins == 0 ? "R5 clock count" : "R6 clock count", 32'(rises), ins == 0 ? 32'd16 : 32'd24);
      check("R6 single chip-select low", 32'(cs_falls), 32'd1);
      check("R2 sclk period", 32'(period_bad), 32'd0);
      check("R12 gap", 32'(gap_bad), 32'd0);
      if (ins == 0) check("R5 mosi quiet", 32'(mosi_bits), 32'd0);
      else check(ins == 1 ? "R3 command" : "R4 command", 32'(mosi_bits[23:16]),
                 32'(exp_cmd(ins, ch, d)));
      @(negedge clk);
      check("R12 done one cycle", 32'(done), 32'd0);
      while (busy) @(negedge clk);
   endtask

   task automatic bad_req(input int ins, input int res, input int ch);
      int seen = 0;
      @(negedge clk);
      cs_falls = 0;
      in_sel = 2'(ins); res_sel = 2'(res); chan = 3'(ch); diff = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (err) seen = seen + 1;
      check("R11 busy low", 32'(busy), 32'd0);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (err) seen = seen + 1;
      end
      check("R11 error pulse", 32'(seen), 32'd1);
      check("R11 no chip select", 32'(cs_falls), 32'd0);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R1 cs_n", 32'(cs_n), 32'd1);
      check("R1 sclk", 32'(sclk), 32'd0);
      check("R1 mosi", 32'(mosi), 32'd0);
      check("R1 strobes", {29'd0, busy, done, err}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // directed corners
      txn(0, 2, 0, 1'b1, 16'hF000, 1'b0);   // R10 most negative
      txn(0, 2, 0, 1'b0, 16'hEFFF, 1'b0);   // R10 largest positive, upper bits ignored
      txn(1, 1, 1, 1'b1, 16'hABCD, 1'b0);   // R3 differential 1-0
      txn(3, 0, 7, 1'b0, 16'hFFC0, 1'b0);   // R4 top channel
      txn(2, 1, 3, 1'b1, 16'h1234, 1'b1);   // R12 start while busy ignored
      txn(0, 0, 0, 1'b0, 16'hFFFF, 1'b0);   // R9 masking
      bad_req(1, 0, 2);
      bad_req(0, 3, 0);
      bad_req(2, 2, 0);
      bad_req(0, 0, 1);
      // seeded random mix
      for (int k = 0; k < 40; k++) begin
         int ins, res, ch;
         ins = int'($urandom % 4);
         res = (ins == 0) ? int'($urandom % 3) : int'($urandom % 2);
         ch  = int'($urandom % (1 << ins));
         txn(ins, res, ch, 1'($urandom), 16'($urandom), 1'b0);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule